// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Flash Mode Model

A synthesizable, clocked behavioural model of a byte-wide flash array that can be rewritten many times by an external programmer. It stands as the device under test for programmer logic. The block decodes its operating mode from the active-low chip, output and write enables, plus two flags that show when the output-enable pin or address bit 9 is held at the high programming voltage. It does not use a command sequence. From those inputs it reads the array, returns identification bytes, programs single bytes or erases the whole array.

Programming is an AND of new data into the stored byte, so bits can only go from 1 to 0. A full-array erase is the only way back to all ones. Erase and program timing are counted in clock cycles. The model has no analog levels and no pin timing.

Top module: `mtp_flash_model`

## Requirements
- R1: With ce_n=0, oe_n=0, oe_hv=0 and a9_hv=0, dout_en is 1 and dout carries the stored byte at addr in the same cycle, with no clock edge needed.
- R2: With ce_n=1 (standby), dout_en is 0 whatever the other inputs are.
- R3: With oe_n=1, or with oe_hv=1, dout_en is 0.
- R4: Program mode is ce_n=0, oe_hv=1, a9_hv=0. A write-enable pulse is sampled low on MIN_PULSE or more consecutive rising edges and is then sampled high. That pulse stores (old byte AND din) at addr, using the addr and din held at its last low sample. The new value can be read from the next cycle on.
- R5: Programming never turns a 0 bit into 1. Programming 8'h00 and then 8'hFF leaves 8'h00.
- R6: A program pulse with 1 to MIN_PULSE-1 low samples leaves the byte unchanged. It also sets pulse_err, which stays 1 until reset.
- R7: Erase mode is ce_n=0, oe_hv=1, a9_hv=1. In this mode, we_n sampled high and then low on consecutive edges starts an erase. busy is 1 from that edge for exactly ERASE_CYC cycles.
- R8: While busy=1, the array keeps its old contents and program pulses have no effect. When busy falls, every byte reads 8'hFF.
- R9: ID mode is ce_n=0, oe_n=0, we_n=1, a9_hv=1, oe_hv=0. In ID mode dout_en is 1, and dout is 8'hBF with addr[0]=0 or DEV_CODE with addr[0]=1. With a9_hv=1 and we_n=0, dout_en is 0.
- R10: After reset, busy=0, pulse_err=0 and every byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_hv | input | 1 | Output-enable pin at programming voltage |
| a9_hv | input | 1 | Address bit 9 at programming voltage |
| din | input | 8 | Program data |
| dout | output | 8 | Read or ID data, 0 when not driven |
| dout_en | output | 1 | Data bus driven |
| busy | output | 1 | Erase in progress |
| pulse_err | output | 1 | Sticky short program pulse flag |

## Verification
The assertions assume that rst_n is held low for at least one clock and that the inputs change only between clock edges. Under that assumption, each sampled edge sees one settled mode. The stimulus drives every input on the falling clock edge. It never raises the high-voltage flags during a read, and it starts each program or erase with write enable already high. As a result, each mode change lands a full half cycle before the edge that samples it. Constrained-random program pulse widths fall on both sides of the minimum width.

// File: rtl/mtp_flash_model.sv
module mtp_flash_model #(
  parameter int          ADDR_W    = 10,
  parameter logic [7:0]  DEV_CODE  = 8'hC6,
  parameter int          ERASE_CYC = 64,
  parameter int          MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy,
  output logic              pulse_err
);
  localparam int         DEPTH = 1 << ADDR_W;
  localparam int         EC_W  = $clog2(ERASE_CYC + 1);
  localparam int         PC_W  = $clog2(MIN_PULSE + 1);
  localparam logic [7:0] MFR   = 8'hBF;

  logic [7:0]        mem [DEPTH];
  logic              we_q;
  logic [PC_W-1:0]   pcnt;
  logic [EC_W-1:0]   ecnt;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;

  wire prog_mode  = !ce_n && oe_hv && !a9_hv;
  wire erase_mode = !ce_n && oe_hv && a9_hv;
  wire id_mode    = !ce_n && !oe_n && !oe_hv && a9_hv && we_n;
  wire rd_mode    = !ce_n && !oe_n && !oe_hv && !a9_hv;
  wire we_rise    = we_n && !we_q;
  wire pulse_ok   = pcnt >= PC_W'(MIN_PULSE);
  wire prog_fire  = prog_mode && we_rise && pulse_ok && !busy;
  wire prog_short = prog_mode && we_rise && !pulse_ok && (pcnt != '0) && !busy;
  wire erase_go   = erase_mode && !we_n && we_q && !busy;
  wire erase_done = busy && (ecnt == '0);

  assign dout_en = rd_mode || id_mode;
  assign dout    = id_mode ? (addr[0] ? DEV_CODE : MFR) :
                   rd_mode ? mem[addr] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      pcnt      <= '0;
      ecnt      <= '0;
      busy      <= 1'b0;
      pulse_err <= 1'b0;
      waddr     <= '0;
      wdata     <= 8'hFF;
    end else begin
      we_q <= we_n;
      if (!prog_mode || busy || we_n) pcnt <= '0;
      else if (!pulse_ok)             pcnt <= pcnt + 1'b1;
      if (prog_mode && !we_n) begin
        waddr <= addr;
        wdata <= din;
      end
      if (prog_short) pulse_err <= 1'b1;
      if (erase_go) begin
        busy <= 1'b1;
        ecnt <= EC_W'(ERASE_CYC - 1);
      end else if (erase_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        ecnt <= ecnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || erase_done) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_fire) begin
      mem[waddr] <= mem[waddr] & wdata;
    end
  end
endmodule

// File: rtl/mtp_flash_chk.sv
module mtp_flash_chk #(
  parameter int ERASE_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic oe_hv,
  input logic a9_hv,
  input logic dout_en,
  input logic busy,
  input logic pulse_err
);
  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;

  p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || oe_hv) |-> !dout_en);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);
  p_erase_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!ce_n && oe_hv && a9_hv && !we_n));
  p_erase_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < ERASE_CYC));
  p_id_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !oe_hv && a9_hv && !we_n) |-> !dout_en);
endmodule

bind mtp_flash_model mtp_flash_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .oe_hv(oe_hv), .a9_hv(a9_hv), .dout_en(dout_en), .busy(busy),
  .pulse_err(pulse_err)
);

// File: tb/sim_mtp_flash_model.sv
module sim_mtp_flash_model;
  localparam int         AW    = 10;
  localparam int         DEPTH = 1 << AW;
  localparam int         EC    = 64;
  localparam int         MP    = 4;
  localparam logic [7:0] DEVC  = 8'hC6;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1, oe_n = 1, we_n = 1, oe_hv = 0, a9_hv = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic dout_en, busy, pulse_err;

  int nvec = 0, nfail = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];
  bit err_exp = 0;

  always #2.5 clk = ~clk;

  mtp_flash_model #(.ADDR_W(AW), .DEV_CODE(DEVC), .ERASE_CYC(EC), .MIN_PULSE(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .oe_hv(oe_hv), .a9_hv(a9_hv), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .pulse_err(pulse_err));

  function automatic logic [7:0] prog_result(logic [7:0] old, logic [7:0] d);
    return old & d;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; oe_hv = 0; a9_hv = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    @(negedge clk);
    idle(); ce_n = 0; oe_n = 0; addr = a;
    #1;
    chk({tag, " en"}, dout_en, 1);
    chk({tag, " data"}, dout, ref_mem[a]);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d, int width);
    @(negedge clk);
    idle(); ce_n = 0; oe_hv = 1; addr = a; din = d;
    @(negedge clk);
    we_n = 0;
    repeat (width) @(negedge clk);
    we_n = 1;
    @(negedge clk);
    idle();
    if (width >= MP) ref_mem[a] = prog_result(ref_mem[a], d);
    else err_exp = 1;
  endtask

  task automatic erase(logic [AW-1:0] probe);
    @(negedge clk);
    idle(); ce_n = 0; oe_hv = 1; a9_hv = 1;
    @(negedge clk);
    we_n = 0;
    @(negedge clk);
    we_n = 1; oe_hv = 0; a9_hv = 0; oe_n = 0; addr = probe;
    #1;
    chk("R7 busy after start", busy, 1);
    chk("R8 old data while busy", dout, ref_mem[probe]);
    repeat (EC - 1) @(negedge clk);
    #1;
    chk("R7 busy at last cycle", busy, 1);
    chk("R8 still old at last busy cycle", dout, ref_mem[probe]);
    @(negedge clk);
    #1;
    chk("R7 busy cleared", busy, 0);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    chk("R8 erased byte", dout, 8'hFF);
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 pulse_err", pulse_err, 0);
    rd(0, "R10 first");
    rd(DEPTH - 1, "R10 last");

    // R2 standby and R3 output disable
    @(negedge clk); idle(); oe_n = 0; #1;
    chk("R2 standby", dout_en, 0);
    ce_n = 0; oe_n = 1; #1;
    chk("R3 oe high", dout_en, 0);
    oe_n = 0; oe_hv = 1; #1;
    chk("R3 oe at hv", dout_en, 0);

    // R9 identification
    @(negedge clk); idle(); ce_n = 0; oe_n = 0; a9_hv = 1; addr = '0; #1;
    chk("R9 en", dout_en, 1);
    chk("R9 mfr", dout, 8'hBF);
    addr = 1; #1;
    chk("R9 dev", dout, DEVC);
    we_n = 0; #1;
    chk("R9 we low", dout_en, 0);
    idle();

    // R4/R5 directed
    prog(10'h155, 8'h00, MP);
    rd(10'h155, "R4 exact min pulse");
    prog(10'h155, 8'hFF, MP + 2);
    rd(10'h155, "R5 no set bits");
    chk("R6 no err yet", pulse_err, 0);
    prog(10'h0AA, 8'h3C, MP - 1);
    rd(10'h0AA, "R6 short unchanged");
    chk("R6 err set", pulse_err, 1);
    prog(10'h0AA, 8'h5A, 1);
    chk("R6 err held", pulse_err, 1);

    // R7/R8 erase, then program during busy ignored
    erase(10'h155);
    @(negedge clk); idle(); ce_n = 0; oe_hv = 1; a9_hv = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1; a9_hv = 0;
    @(negedge clk); we_n = 0; addr = 10'h011; din = 8'h00;
    repeat (MP + 1) @(negedge clk);
    we_n = 1;
    @(negedge clk); idle();
    repeat (EC) @(negedge clk);
    rd(10'h011, "R8 prog while busy ignored");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, DEPTH - 1));
      case ($urandom_range(0, 9))
        0, 1, 2, 3: prog(a, 8'($urandom), $urandom_range(1, MP + 3));
        9: if (n % 97 == 0) erase(a); else rd(a, "R1 random read");
        default: rd(a, "R1 random read");
      endcase
      #1;
      chk("R6 err flag", pulse_err, err_exp);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule